// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned 32-bit operands into a 64-bit product over many clock cycles. It uses one 32-bit adder and a single 64-bit product register. When a start request is accepted, the block captures the multiplicand into its own register. It places the multiplier in the low half of the product register and clears the high half. On every following cycle the block looks at the product's least significant bit. If that bit is set, it adds the multiplicand into the high half. It then shifts the whole register one place to the right in the same cycle. The multiplier is used up by this shift, and the finished product fills the register.

The carry out of the adder is kept as an extra bit and enters the top of the register during the shift, so no sum bit is lost. After 32 steps the block raises a one-cycle completion pulse. The product then stays on the output until the next accepted start. A start request that arrives during a multiplication is ignored.

Top module: `shiftadd_mult`

## Requirements
- R1: While reset is low at a clock edge, the product output becomes all zeros and the completion pulse becomes low.
- R2: At the clock edge where a start is accepted (start high while idle), the product output takes the value {32'b0, multiplier}.
- R3: The completion pulse is high in the cycle that follows the 32nd clock edge after the edge that accepted the start.
- R4: When the completion pulse is high, the product output equals the unsigned 64-bit product of the two operands captured at the accepting edge.
- R5: The carry out of each addition is kept, so all-ones operands give 0xFFFFFFFE00000001 and 0xFFFFFFFF × 1 gives 0x00000000FFFFFFFF.
- R6: The completion pulse lasts exactly one cycle.
- R7: While the block is idle and start is low, the product output does not change.
- R8: A start that is high while a multiplication is running has no effect: the running result and its completion timing are unchanged.
- R9: Operand inputs are sampled only at the accepting edge. Changing them during a run does not alter the result.
- R10: After each step k (k = 1..32) the product register holds floor(B / 2^k) + A × (B mod 2^k) × 2^(32-k), where A is the multiplicand and B the multiplier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication; accepted only while idle |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| product_o | output | 64 | Product register contents; the final product after completion |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the clock runs without stopping and that reset is held for at least one edge before the first start. They also assume that the result is judged against operands latched at the accepting edge, not against the live operand inputs. The stimulus keeps within these limits. It holds reset for several edges and drives every input on the falling edge. It also changes the operand inputs on every cycle of a run and raises start in the middle of a run, so that the latching and ignore rules are tested and not merely met by chance. Corner operands 0, 1 and all-ones, along with random pairs, exercise the carry path and the intermediate register values.

// File: rtl/mul_pkg.sv
// Package: shared types for the shift-add multiplier.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package mul_pkg;

    // Sequencer state: waiting for a start, or stepping through bits.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_t;

endpackage

// File: rtl/mul_cond_add.sv
// Module: mul_cond_add
// Purpose: adds the addend to the accumulator when enabled, through a ripple
// chain of one-bit full adders. The carry out is kept as the top sum bit.
// Assumes: purely combinational; the caller registers the result.
module mul_cond_add #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] addend_i,
    input  logic             en_i,
    output logic [WIDTH:0]   sum_o
);

    logic [WIDTH-1:0] gated_w;
    logic [WIDTH:0]   carry_w;

    // Gate the addend: when not enabled the sum passes the accumulator.
    always_comb gated_w = en_i ? addend_i : '0;

    assign carry_w[0] = 1'b0;

    // One full adder per bit, carry rippling upward.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_fa
        assign sum_o[gi]      = acc_i[gi] ^ gated_w[gi] ^ carry_w[gi];
        assign carry_w[gi+1]  = (acc_i[gi] & gated_w[gi])
                              | (carry_w[gi] & (acc_i[gi] ^ gated_w[gi]));
    end

    assign sum_o[WIDTH] = carry_w[WIDTH];

endmodule

// File: rtl/mul_ctrl.sv
// Module: mul_ctrl
// Purpose: sequencer. It accepts a start while idle, issues WIDTH step
// strobes, then pulses done for one cycle.
// Assumes: WIDTH >= 2; start while running is ignored.
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    mul_state_t    state_q;
    logic [CW-1:0] step_cnt_q;

    // Decode the strobes from the current state.
    always_comb begin
        load_o = (state_q == ST_IDLE) && start_i;
        step_o = (state_q == ST_RUN);
        busy_o = (state_q == ST_RUN);
    end

    // State, step counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_cnt_q <= '0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                state_q    <= ST_RUN;
                step_cnt_q <= '0;
            end else if (step_o) begin
                step_cnt_q <= step_cnt_q + 1'b1;
                if (step_cnt_q == LAST_STEP) begin
                    state_q <= ST_IDLE;
                    done_o  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mul_prod_reg.sv
// Module: mul_prod_reg
// Purpose: holds the multiplicand and the double-width product register.
// On load it stores {0, multiplier}. On each step it conditionally adds
// into the high half and shifts right, the adder carry entering the top bit.
// Assumes: load and step are never high together.
module mul_prod_reg #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] product_o
);

    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    prod_q;
    logic [WIDTH:0]   sum_w;
    logic [PW-1:0]    next_w;

    // The adder acts on the high half, enabled by the current low bit.
    mul_cond_add #(.WIDTH(WIDTH)) u_add (
        .acc_i    (prod_q[PW-1:WIDTH]),
        .addend_i (mcand_q),
        .en_i     (prod_q[0]),
        .sum_o    (sum_w)
    );

    // The carry, the sum and the remaining low bits, shifted right by one.
    always_comb next_w = {sum_w, prod_q[WIDTH-1:1]};

    // Register update: load operands, or take one add-and-shift step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load_i) begin
            mcand_q <= mcand_i;
            prod_q  <= {{WIDTH{1'b0}}, mplier_i};
        end else if (step_i) begin
            prod_q  <= next_w;
        end
    end

    assign product_o = prod_q;

endmodule

// File: rtl/shiftadd_mult.sv
// Module: shiftadd_mult
// Purpose: top level of the multi-cycle unsigned shift-add multiplier.
// Assumes: synchronous active-low reset; the result is valid while done_o
// is high and is held afterwards until the next accepted start.
module shiftadd_mult #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] product_o,
    output logic               done_o
);

    logic load_w;
    logic step_w;
    logic busy_w;

    // Sequencing of load, steps and completion.
    mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load_w),
        .step_o  (step_w),
        .busy_o  (busy_w),
        .done_o  (done_o)
    );

    // Operand and product storage with the adder.
    mul_prod_reg #(.WIDTH(WIDTH)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_w),
        .step_i    (step_w),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .product_o (product_o)
    );

endmodule

// File: rtl/mul_checker.sv
// Module: mul_checker
// Purpose: temporal properties of shiftadd_mult, bound to the top.
// Assumes: busy is the top's internal running flag.
module mul_checker #(
    parameter int WIDTH = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               busy,
    input logic               done_o,
    input logic [WIDTH-1:0]   mcand_i,
    input logic [WIDTH-1:0]   mplier_i,
    input logic [2*WIDTH-1:0] product_o
);

    localparam int CNW = $clog2(WIDTH + 1) + 1;

    logic [CNW-1:0]   cyc_q;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic             accept_w;

    always_comb accept_w = start_i && !busy;

    // Count the edges since acceptance and latch the accepted operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else if (accept_w) begin
            cyc_q <= '0;
            a_q   <= mcand_i;
            b_q   <= mplier_i;
        end else if (busy) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // R2: an accepted start loads the multiplier into the low half.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_w |=> (busy && product_o == {{WIDTH{1'b0}}, $past(mplier_i)}));

    // R3: completion comes WIDTH edges after acceptance.
    p_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc_q == CNW'(WIDTH)));

    // R4: the product is correct at completion.
    p_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == ({{WIDTH{1'b0}}, a_q} * {{WIDTH{1'b0}}, b_q})));

    // R6: the completion pulse is a single cycle.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: the product holds while idle without a start.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> $stable(product_o));

    // R8: a start during a run does not restart the operation.
    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i && cyc_q < CNW'(WIDTH - 1)) |=> busy);

endmodule

bind shiftadd_mult mul_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy      (busy_w),
    .done_o    (done_o),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o)
);

// File: tb/sim_shiftadd_mult.sv
// Bench for shiftadd_mult: a behavioural per-cycle reference model
// compared on every falling edge, plus directed checks.
module sim_shiftadd_mult;

    localparam int W       = 32;
    localparam int CLK_PER = 10;
    localparam int WD_MAX  = 150000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [W-1:0]   mcand_i = '0;
    logic [W-1:0]   mplier_i = '0;
    logic [2*W-1:0] product_o;
    logic           done_o;

    int total = 0;
    int bad   = 0;
    int wd    = 0;
    string cur_req = "R10";

    // Reference model state.
    bit             m_busy = 0;
    bit             m_done = 0;
    int             m_k = 0;
    logic [W-1:0]   m_a = '0;
    logic [W-1:0]   m_b = '0;
    logic [2*W-1:0] m_prod = '0;

    shiftadd_mult #(.WIDTH(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .product_o (product_o),
        .done_o    (done_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Register value after k steps, from arithmetic alone (R10).
    function automatic logic [2*W-1:0] after_steps(logic [W-1:0] a, logic [W-1:0] b, int k);
        logic [127:0] lowb;
        logic [127:0] acc;
        lowb = (k >= W) ? {96'b0, b} : ({96'b0, b} & ((128'd1 << k) - 128'd1));
        acc  = (({96'b0, a} * lowb) << (W - k)) + ({96'b0, b} >> k);
        return acc[2*W-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_k <= 0; m_prod <= '0;
        end else begin
            m_done <= 0;
            if (!m_busy && start_i) begin
                m_a <= mcand_i; m_b <= mplier_i; m_k <= 0; m_busy <= 1;
                m_prod <= {{W{1'b0}}, mplier_i};
            end else if (m_busy) begin
                m_prod <= after_steps(m_a, m_b, m_k + 1);
                m_k <= m_k + 1;
                if (m_k + 1 == W) begin
                    m_busy <= 0; m_done <= 1;
                end
            end
        end
    end

    // Per-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(product_o == m_prod, cur_req, product_o, m_prod);
            chk(done_o == m_done, "R3", 64'(done_o), 64'(m_done));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > WD_MAX) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=%0d", wd, WD_MAX);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // One multiplication with operands scrambled during the run (R9);
    // poke raises start in mid-run (R8).
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke, input string rreq);
        int n;
        logic [2*W-1:0] keep;
        logic [2*W-1:0] want;
        want = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        @(negedge clk);
        mcand_i = a; mplier_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(product_o == {{W{1'b0}}, b}, "R2", product_o, {{W{1'b0}}, b});
        mcand_i = $urandom; mplier_i = $urandom;
        n = 1;
        while (!done_o && n < W + 8) begin
            @(negedge clk);
            n++;
            mcand_i = $urandom; mplier_i = $urandom;
            start_i = (poke && n == 10);
        end
        start_i = 1'b0;
        chk(n == W + 1, poke ? "R8" : "R3", 64'(n), 64'(W + 1));
        chk(product_o == want, rreq, product_o, want);
        chk(product_o == want, "R9", product_o, want);
        @(negedge clk);
        chk(!done_o, "R6", 64'(done_o), 64'd0);
        keep = product_o;
        repeat (4) begin
            @(negedge clk);
            chk(product_o == keep, "R7", product_o, keep);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(product_o == '0, "R1", product_o, 64'd0);
        chk(done_o == 1'b0, "R1", 64'(done_o), 64'd0);
        rst_n = 1'b1;

        run_mul(32'd0, 32'd0, 0, "R4");
        run_mul(32'd0, 32'hDEADBEEF, 0, "R4");
        run_mul(32'h12345678, 32'd0, 0, "R4");
        run_mul(32'd1, 32'hCAFEF00D, 0, "R4");
        run_mul(32'h80000001, 32'd1, 0, "R4");
        run_mul(32'hFFFFFFFF, 32'hFFFFFFFF, 0, "R5");
        run_mul(32'hFFFFFFFF, 32'd1, 0, "R5");
        run_mul(32'd1, 32'hFFFFFFFF, 0, "R5");
        run_mul(32'd17, 32'd19, 0, "R4");
        run_mul(32'hA5A5A5A5, 32'h5A5A5A5A, 1, "R8");
        for (int i = 0; i < 20; i++) begin
            run_mul($urandom, $urandom, (i % 4) == 0, "R4");
        end

        // Reset in mid-run returns to the reset state (R1).
        @(negedge clk);
        mcand_i = 32'h3; mplier_i = 32'h7; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(product_o == '0, "R1", product_o, 64'd0);
        chk(done_o == 1'b0, "R1", 64'(done_o), 64'd0);
        rst_n = 1'b1;
        run_mul(32'h3, 32'h7, 0, "R4");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule